// File: doc/BRIEF.md
# Second-Operand Shifter and Rotator

This combinational unit forms the second ALU operand of a data-processing instruction, together with a shifter carry-out, from the low twelve bits of the instruction. The caller supplies the 12-bit operand field, a format-select bit, the value of the shifted register, the value of the amount register and the current carry flag. Register-file reads happen before the unit and flag write-back after it. The unit only selects bits and shifts them.

In immediate format an 8-bit constant is rotated right by an even distance. In register format the register value is shifted left logically, right logically, right arithmetically or rotated. The distance comes either from a 5-bit field in the instruction or from the low byte of a second register. The zero-distance encodings have their own meanings. A zero logical left shift is a plain move. A zero-field logical or arithmetic right shift means a shift by 32. A zero-field rotate means a one-bit rotate through the carry.

Top module: `op2_shifter`

## Requirements
- R1: With `imm_sel_i`=1, `operand_o` equals `{24'b0, op2_i[7:0]}` rotated right by `2*op2_i[11:8]`. Field 0x203 gives 0x30000000.
- R2: With `imm_sel_i`=1, `carry_o` equals `operand_o[31]` when `op2_i[11:8]` is nonzero, and equals `carry_i` otherwise.
- R3: With `imm_sel_i`=0, `op2_i[6:5]` selects the shift kind (00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right). `op2_i[4]`=0 takes the distance from `op2_i[11:7]`, and `op2_i[4]`=1 takes it from `rs_i`. Bits 3:0 and 11:8 are register selects that are decoded elsewhere, and they do not affect the result.
- R4: A left logical shift with a zero field distance passes `rm_i` unchanged with `carry_o`=`carry_i`. Field 0x182 gives `rm_i` shifted left by 3.
- R5: A right logical or right arithmetic shift with a zero field distance acts as a shift by 32. The result is zero for the logical shift or 32 copies of `rm_i[31]` for the arithmetic shift, and `carry_o`=`rm_i[31]`.
- R6: A rotate with a zero field distance is a one-bit rotate through carry: `operand_o`=`{carry_i, rm_i[31:1]}` and `carry_o`=`rm_i[0]`.
- R7: For any nonzero effective distance, `carry_o` is the last bit shifted out of `rm_i` (for a rotate, `operand_o[31]`).
- R8: A register-supplied distance uses only `rs_i[7:0]`. A value of zero there passes `rm_i` unchanged with `carry_o`=`carry_i`.
- R9: For a register-supplied distance, a logical shift by 32 gives zero with carry `rm_i[0]` (left) or `rm_i[31]` (right). A logical shift by more than 32 gives zero with carry 0. An arithmetic shift by 32 or more gives 32 copies of `rm_i[31]` with carry `rm_i[31]`.
- R10: A register-supplied rotate uses the distance modulo 32. A nonzero multiple of 32 leaves `rm_i` unchanged with `carry_o`=`rm_i[31]`.
- R11: Field 0x352 with `rs_i`=3 gives `rm_i` arithmetically shifted right by 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op2_i | input | 12 | Low twelve bits of the instruction |
| imm_sel_i | input | 1 | 1 = rotated-constant format, 0 = register format |
| rm_i | input | 32 | Value of the register being shifted |
| rs_i | input | 32 | Value of the register holding the shift distance |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The operand field is walked through the constant format with zero, small and wrap-around rotations. This separates a correct doubling of the rotate field and a correct carry choice from an off-by-one in the rotation. Each shift kind is then applied with field distances of zero and nonzero. This shows whether the zero encodings are decoded as move, shift-by-32 or rotate-through-carry rather than as literal zero shifts. Register distances of 0, 32, just over 32, above 255 and nonzero multiples of 32 tell the saturation, byte truncation and modulo paths apart. A long sweep of random fields and values against an independent bit-at-a-time model catches wrong carry bits and any leakage from the register-select bits.

// File: rtl/op2_shifter.sv
module op2_shifter (
  input  logic [11:0] op2_i,
  input  logic        imm_sel_i,
  input  logic [31:0] rm_i,
  input  logic [31:0] rs_i,
  input  logic        carry_i,
  output logic [31:0] operand_o,
  output logic        carry_o
);

  typedef enum logic [1:0] {SH_LSL = 2'b00, SH_LSR = 2'b01, SH_ASR = 2'b10, SH_ROR = 2'b11} shift_e;

  shift_e      kind;
  logic        reg_amt;
  logic [4:0]  fld_amt;
  logic [7:0]  rs_amt;
  logic [3:0]  rot;

  assign kind    = shift_e'(op2_i[6:5]);
  assign reg_amt = op2_i[4];
  assign fld_amt = op2_i[11:7];
  assign rs_amt  = rs_i[7:0];
  assign rot     = op2_i[11:8];

  logic unused_bits;
  assign unused_bits = ^{op2_i[3:0], rs_i[31:8]};

  // rotated constant
  logic [63:0] imm_dup;
  logic [31:0] imm_val;
  assign imm_dup = {24'd0, op2_i[7:0], 24'd0, op2_i[7:0]} >> {rot, 1'b0};
  assign imm_val = imm_dup[31:0];

  // effective distance, saturated at 33
  logic [5:0] amt;
  logic       rrx;
  always_comb begin
    rrx = 1'b0;
    if (reg_amt) begin
      amt = (rs_amt > 8'd32) ? 6'd33 : rs_amt[5:0];
    end else if (fld_amt == 5'd0) begin
      case (kind)
        SH_LSR, SH_ASR: amt = 6'd32;
        SH_ROR: begin amt = 6'd0; rrx = 1'b1; end
        default: amt = 6'd0;
      endcase
    end else begin
      amt = {1'b0, fld_amt};
    end
  end

  logic [32:0] lsl_t, lsr_t, asr_t;
  logic [4:0]  ror_n;
  logic [63:0] ror_t;
  assign lsl_t = {1'b0, rm_i} << amt;
  assign lsr_t = {rm_i, 1'b0} >> amt;
  assign asr_t = $signed({rm_i, 1'b0}) >>> amt;
  assign ror_n = reg_amt ? rs_amt[4:0] : fld_amt;
  assign ror_t = {rm_i, rm_i} >> ror_n;

  always_comb begin
    operand_o = rm_i;
    carry_o   = carry_i;
    if (imm_sel_i) begin
      operand_o = imm_val;
      carry_o   = (rot == 4'd0) ? carry_i : imm_val[31];
    end else if (rrx) begin
      operand_o = {carry_i, rm_i[31:1]};
      carry_o   = rm_i[0];
    end else if (amt != 6'd0) begin
      case (kind)
        SH_LSL: {carry_o, operand_o} = lsl_t;
        SH_LSR: {operand_o, carry_o} = lsr_t;
        SH_ASR: {operand_o, carry_o} = asr_t;
        default: begin
          operand_o = ror_t[31:0];
          carry_o   = ror_t[31];
        end
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({op2_i, imm_sel_i, rm_i, rs_i, carry_i})) begin
      if (imm_sel_i && rot != 4'd0)
        p_imm_carry_r2: assert (carry_o == operand_o[31]) else $error("imm carry");
      if (!imm_sel_i && !reg_amt && kind == SH_ROR && fld_amt == 5'd0)
        p_rrx_r6: assert (operand_o == {carry_i, rm_i[31:1]} && carry_o == rm_i[0]) else $error("rrx");
      if (!imm_sel_i && reg_amt && rs_amt == 8'd0)
        p_zero_pass_r8: assert (operand_o == rm_i && carry_o == carry_i) else $error("zero pass");
      if (!imm_sel_i && reg_amt && rs_amt >= 8'd32 && (kind == SH_LSL || kind == SH_LSR))
        p_big_zero_r9: assert (operand_o == 32'd0) else $error("big shift");
      if (!imm_sel_i && reg_amt && rs_amt >= 8'd32 && kind == SH_ASR)
        p_asr_fill_r9: assert (operand_o == {32{rm_i[31]}} && carry_o == rm_i[31]) else $error("asr fill");
      if (!imm_sel_i && reg_amt && kind == SH_ROR && rs_amt != 8'd0)
        p_ror_carry_r10: assert (carry_o == operand_o[31]) else $error("ror carry");
    end
  end

endmodule

// File: tb/op2_shifter_test.sv
module op2_shifter_test;
  logic        clk = 1'b0;
  logic [11:0] op2;
  logic        imm_sel;
  logic [31:0] rm, rs;
  logic        cin;
  logic [31:0] res;
  logic        cout;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  op2_shifter uut (
    .op2_i(op2), .imm_sel_i(imm_sel), .rm_i(rm), .rs_i(rs),
    .carry_i(cin), .operand_o(res), .carry_o(cout)
  );

  function automatic logic [32:0] ref_model(input logic [11:0] f, input logic im,
                                             input logic [31:0] a, input logic [31:0] s,
                                             input logic ci);
    logic [31:0] v;
    logic        c;
    int          n;
    c = ci;
    if (im) begin
      v = {24'd0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) begin
        c = v[0];
        v = {v[0], v[31:1]};
      end
      return {c, v};
    end
    v = a;
    if (f[4]) n = int'(s[7:0]);
    else n = int'(f[11:7]);
    if (!f[4] && n == 0) begin
      if (f[6:5] == 2'b11) return {a[0], ci, a[31:1]};
      if (f[6:5] != 2'b00) n = 32;
    end
    for (int i = 0; i < n; i++) begin
      case (f[6:5])
        2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic apply(input logic [11:0] f, input logic im, input logic [31:0] a,
                       input logic [31:0] s, input logic ci,
                       input logic [31:0] ev, input logic ec, input string tag);
    @(negedge clk);
    op2 = f; imm_sel = im; rm = a; rs = s; cin = ci;
    #2;
    nchk++;
    if (res !== ev || cout !== ec) begin
      nerr++;
      $display("FAIL %s field=%h rm=%h rs=%h cin=%b: got %h/%b expected %h/%b",
               tag, f, a, s, ci, res, cout, ev, ec);
    end
  endtask

  task automatic t_idle;
    apply(12'h000, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0, "R3 idle zero");
  endtask

  task automatic t_imm_rot;
    apply(12'h203, 1'b1, 32'h1234, 32'h0, 1'b1, 32'h3000_0000, 1'b0, "R1 3 ror 4");
    apply(12'h0FF, 1'b1, 32'h0, 32'h0, 1'b1, 32'h0000_00FF, 1'b1, "R2 rot0 carry");
    apply(12'h102, 1'b1, 32'h0, 32'h0, 1'b0, 32'h8000_0000, 1'b1, "R2 carry bit31");
    apply(12'hF21, 1'b1, 32'h0, 32'h0, 1'b1, 32'h0000_0084, 1'b0, "R1 wrap ror30");
  endtask

  task automatic t_move;
    apply(12'h002, 1'b0, 32'hDEAD_BEEF, 32'h0, 1'b1, 32'hDEAD_BEEF, 1'b1, "R4 move");
    apply(12'h182, 1'b0, 32'hF000_0001, 32'h0, 1'b0, 32'h8000_0008, 1'b1, "R4 lsl 3");
  endtask

  task automatic t_field_32;
    apply(12'h020, 1'b0, 32'h8000_0000, 32'h0, 1'b0, 32'h0, 1'b1, "R5 lsr 32");
    apply(12'h040, 1'b0, 32'h8000_0000, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b1, "R5 asr 32 neg");
    apply(12'h040, 1'b0, 32'h7FFF_FFFF, 32'h0, 1'b1, 32'h0, 1'b0, "R5 asr 32 pos");
  endtask

  task automatic t_rrx;
    apply(12'h060, 1'b0, 32'h0000_0003, 32'h0, 1'b1, 32'h8000_0001, 1'b1, "R6 rrx c1");
    apply(12'h060, 1'b0, 32'h0000_0002, 32'h0, 1'b0, 32'h0000_0001, 1'b0, "R6 rrx c0");
  endtask

  task automatic t_carry;
    apply(12'h220, 1'b0, 32'h0000_001F, 32'h0, 1'b0, 32'h0000_0001, 1'b1, "R7 lsr 4");
    apply(12'h460, 1'b0, 32'h1234_5680, 32'h0, 1'b0, 32'h8012_3456, 1'b1, "R7 ror 8");
  endtask

  task automatic t_reg_zero;
    apply(12'h352, 1'b0, 32'h8000_0000, 32'h0000_0100, 1'b1, 32'h8000_0000, 1'b1, "R8 low byte zero");
    apply(12'h310, 1'b0, 32'h0000_0001, 32'hFFFF_FF01, 1'b0, 32'h0000_0002, 1'b0, "R8 low byte only");
  endtask

  task automatic t_reg_big;
    apply(12'h310, 1'b0, 32'h0000_0001, 32'd32, 1'b0, 32'h0, 1'b1, "R9 lsl 32");
    apply(12'h310, 1'b0, 32'hFFFF_FFFF, 32'd33, 1'b1, 32'h0, 1'b0, "R9 lsl 33");
    apply(12'h330, 1'b0, 32'h8000_0000, 32'd32, 1'b0, 32'h0, 1'b1, "R9 lsr 32");
    apply(12'h330, 1'b0, 32'hFFFF_FFFF, 32'd200, 1'b1, 32'h0, 1'b0, "R9 lsr 200");
    apply(12'h350, 1'b0, 32'h8000_0000, 32'd40, 1'b0, 32'hFFFF_FFFF, 1'b1, "R9 asr 40");
  endtask

  task automatic t_reg_ror;
    apply(12'h370, 1'b0, 32'h0000_00F0, 32'd36, 1'b1, 32'h0000_000F, 1'b0, "R10 ror 36");
    apply(12'h370, 1'b0, 32'h8000_0001, 32'd64, 1'b0, 32'h8000_0001, 1'b1, "R10 ror 64");
  endtask

  task automatic t_example;
    apply(12'h352, 1'b0, 32'h8000_0010, 32'd3, 1'b1, 32'hF000_0002, 1'b0, "R11 asr by rs");
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 3000; k++) begin
      logic [11:0] f;
      logic        im, ci;
      logic [31:0] a, s;
      logic [32:0] e;
      f  = 12'($urandom);
      im = 1'($urandom);
      ci = 1'($urandom);
      a  = $urandom;
      s  = (k % 4 == 0) ? 32'($urandom_range(0, 70)) : $urandom;
      e  = ref_model(f, im, a, s, ci);
      apply(f, im, a, s, ci, e[31:0], e[32], "R3 R7 sweep");
    end
  endtask

  initial begin
    op2 = '0; imm_sel = 1'b0; rm = '0; rs = '0; cin = 1'b0;
    t_idle;
    t_imm_rot;
    t_move;
    t_field_32;
    t_rrx;
    t_carry;
    t_reg_zero;
    t_reg_big;
    t_reg_ror;
    t_example;
    t_sweep;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule